// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmit Status Logic

This block holds the transmit data queue and the control/status register for one isochronous IN endpoint of a full-speed device controller. The host side writes packet bytes into the queue through a push port and reads or writes an 8-bit control/status register. The link side (the serial engine) sees whether a packet is ready, drains bytes one at a time, and signals the end of each transmitted packet.

The register gives software a read-only flag saying whether a whole packet's worth of space is free, a sticky packet-sent flag and a sticky underrun flag (both cleared by writing 1), a flush command that empties the queue and never reads back as 1, and a short-packet arm bit. The arm bit is set by writing 1 and stays set until the link reports the packet as sent or a flush cancels it. An interrupt line is raised while either sticky flag is set and the interrupt enable input is high.

Register bit positions: bit 0 room flag, bit 1 packet sent, bit 2 flush, bit 3 underrun, bits 6:4 always 0, bit 7 short packet armed.

Top module: `iso_in_txstat`

## Requirements
- R1: While and directly after reset the register reads 0x01, `irq` is 0 and `link_ready` is 0.
- R2: Bit 0 reads 1 exactly when the free space in the queue (DEPTH minus stored bytes) is at least PKT_BYTES; writes to bit 0 have no effect.
- R3: Pushed bytes reach `link_data` in push order, one byte advancing per accepted `link_pop`; a push while the queue holds DEPTH bytes is dropped.
- R4: A `link_done` pulse sets bit 1 on the next clock; writing 1 to bit 1 clears it, and a `link_done` in the same cycle as the clearing write wins.
- R5: A `link_pop` while the queue is empty sets bit 3 on the next clock; writing 1 to bit 3 clears it, and a new underrun in the same cycle as the clearing write wins.
- R6: Writing 1 to bit 2 empties the queue on the next clock; a push or pop in that cycle is ignored (no byte stored, none consumed, no underrun); bit 2 always reads 0.
- R7: Writing 1 to bit 7 arms a short packet and bit 7 then reads 1 until a `link_done` clears it; writing 0 to bit 7 has no effect; an arming write in the same cycle as `link_done` leaves it armed.
- R8: A flush clears an armed short packet, including when the same write sets bit 7 and bit 2 together.
- R9: Bits 6:4 of the register always read 0.
- R10: `irq` equals `irq_en` AND (bit 1 OR bit 3).
- R11: `link_ready` is 1 when the queue holds at least PKT_BYTES bytes or a short packet is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| irq_en | input | 1 | Transmit interrupt enable |
| irq | output | 1 | Transmit interrupt |
| push_en | input | 1 | Push one byte into the queue |
| push_data | input | DATA_W | Byte to push |
| link_ready | output | 1 | A full or short packet can be sent |
| link_short | output | 1 | Current packet is a short packet |
| link_pop | input | 1 | Link takes the head byte |
| link_data | output | DATA_W | Head byte of the queue |
| link_done | input | 1 | Link finished sending a packet |

## Verification
A wrong byte count in the queue shows at the ports within one clock: the room flag and `link_ready` move at the wrong fill level, and `link_data` presents a byte out of order on the very next pop. A sticky flag stuck or dropped shows in the register and on `irq` the cycle after the event or the clearing write, and a short-packet arm that fails to clear keeps `link_ready` high on an empty queue. The bench runs a behavioural queue model beside the design and compares every output field on every clock, so such a divergence is reported in the cycle it first becomes visible.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;

  // Register bit positions (software decodes these)
  localparam int BIT_ROOM  = 0;
  localparam int BIT_SENT  = 1;
  localparam int BIT_FLUSH = 2;
  localparam int BIT_UNDR  = 3;
  localparam int BIT_SHORT = 7;
  localparam int CSR_W     = 8;

  typedef struct packed {
    logic short_armed;
    logic underrun;
    logic sent;
  } tx_flags_t;

  // Room for one more full packet?
  function automatic logic has_room(input int stored, input int depth, input int pkt);
    return (depth - stored) >= pkt;
  endfunction

  // Enough data stored for a full packet, or a short one armed?
  function automatic logic pkt_ready(input int stored, input int pkt, input logic short_armed);
    return (stored >= pkt) || short_armed;
  endfunction

  // Assemble the register image
  function automatic logic [CSR_W-1:0] pack_csr(input tx_flags_t f, input logic room);
    logic [CSR_W-1:0] v;
    v            = '0;
    v[BIT_ROOM]  = room;
    v[BIT_SENT]  = f.sent;
    v[BIT_UNDR]  = f.underrun;
    v[BIT_SHORT] = f.short_armed;
    return v;
  endfunction

endpackage

// File: rtl/iso_tx_fifo.sv
module iso_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     count,
  output logic              undr_evt
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign push_ok  = push && !flush && (count < CW'(DEPTH));
  assign pop_ok   = pop  && !flush && (count != '0);
  assign undr_evt = pop  && !flush && (count == '0);
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flush) |-> (count == $past(count) || count == $past(count) + CW'(1)
                       || count + CW'(1) == $past(count)));

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/iso_tx_csr.sv
module iso_tx_csr
  import iso_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  input  logic             link_done,
  input  logic             undr_evt,
  input  logic             room,
  input  logic             irq_en,
  output logic [CSR_W-1:0] rdata,
  output logic             flush,
  output logic             short_armed,
  output logic             irq
);

  tx_flags_t flags_q;
  logic      clr_sent, clr_undr, arm_short;

  assign flush     = wr && wdata[BIT_FLUSH];
  assign clr_sent  = wr && wdata[BIT_SENT];
  assign clr_undr  = wr && wdata[BIT_UNDR];
  assign arm_short = wr && wdata[BIT_SHORT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      // sent: event beats clear
      if (link_done)     flags_q.sent <= 1'b1;
      else if (clr_sent) flags_q.sent <= 1'b0;
      // underrun: event beats clear
      if (undr_evt)      flags_q.underrun <= 1'b1;
      else if (clr_undr) flags_q.underrun <= 1'b0;
      // short: flush beats arm, arm beats completion
      if (flush)          flags_q.short_armed <= 1'b0;
      else if (arm_short) flags_q.short_armed <= 1'b1;
      else if (link_done) flags_q.short_armed <= 1'b0;
    end
  end

  assign rdata       = pack_csr(flags_q, room);
  assign short_armed = flags_q.short_armed;
  assign irq         = irq_en && (flags_q.sent || flags_q.underrun);

  // R4
  sent_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_done |=> rdata[BIT_SENT]);

  // R5
  undr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undr_evt |=> rdata[BIT_UNDR]);

  // R7
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_armed && !link_done && !flush) |=> short_armed);

  // R8
  short_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !short_armed);

endmodule

// File: rtl/iso_in_txstat.sv
module iso_in_txstat
  import iso_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 32,
  parameter int PKT_BYTES = 16,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              irq_en,
  output logic              irq,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  output logic              link_ready,
  output logic              link_short,
  input  logic              link_pop,
  output logic [DATA_W-1:0] link_data,
  input  logic              link_done
);

  logic          flush, undr_evt, room, short_armed;
  logic [CW-1:0] count;

  iso_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push_en),
    .push_data (push_data),
    .pop       (link_pop),
    .pop_data  (link_data),
    .count     (count),
    .undr_evt  (undr_evt)
  );

  assign room = has_room(int'(count), DEPTH, PKT_BYTES);

  iso_tx_csr csr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (csr_wr),
    .wdata       (csr_wdata),
    .link_done   (link_done),
    .undr_evt    (undr_evt),
    .room        (room),
    .irq_en      (irq_en),
    .rdata       (csr_rdata),
    .flush       (flush),
    .short_armed (short_armed),
    .irq         (irq)
  );

  assign link_ready = pkt_ready(int'(count), PKT_BYTES, short_armed);
  assign link_short = short_armed;

  // R11
  ready_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !short_armed) |-> !link_ready);

  // R9
  always_comb begin
    if (rst_n) rsvd_zero_chk: assert (csr_rdata[6:4] == 3'b000);
  end

endmodule

// File: tb/iso_in_txstat_tb.sv
module iso_in_txstat_tb_top;

  localparam int DW    = 8;
  localparam int DEPTH = 32;
  localparam int PKT   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_wr = 1'b0;
  logic [7:0]    csr_wdata = '0;
  logic [7:0]    csr_rdata;
  logic          irq_en = 1'b0;
  logic          irq;
  logic          push_en = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic          link_ready, link_short;
  logic          link_pop = 1'b0;
  logic [DW-1:0] link_data;
  logic          link_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  always #4 clk = ~clk;

  iso_in_txstat #(.DATA_W(DW), .DEPTH(DEPTH), .PKT_BYTES(PKT)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .irq_en(irq_en), .irq(irq), .push_en(push_en),
    .push_data(push_data), .link_ready(link_ready), .link_short(link_short),
    .link_pop(link_pop), .link_data(link_data), .link_done(link_done)
  );

  // Behavioural reference
  byte unsigned q[$];
  bit m_sent, m_undr, m_short;
  int sz;
  bit fl;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_sent = 0; m_undr = 0; m_short = 0;
    end else begin
      sz = q.size();
      fl = csr_wr && csr_wdata[2];
      if (fl) q.delete();
      else begin
        if (link_pop) begin
          if (sz == 0) begin
            m_undr = 1;
          end else begin
            void'(q.pop_front());
          end
        end
        if (push_en && sz < DEPTH) q.push_back(push_data);
      end
      if (!(link_pop && sz == 0 && !fl) && csr_wr && csr_wdata[3]) m_undr = 0;
      if (link_done) m_sent = 1;
      else if (csr_wr && csr_wdata[1]) m_sent = 0;
      if (fl) m_short = 0;
      else if (csr_wr && csr_wdata[7]) m_short = 1;
      else if (link_done) m_short = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      chk("R2 room flag", int'(csr_rdata[0]), int'((DEPTH - q.size()) >= PKT));
      chk("R4 sent flag", int'(csr_rdata[1]), int'(m_sent));
      chk("R6 flush bit reads 0", int'(csr_rdata[2]), 0);
      chk("R5 underrun flag", int'(csr_rdata[3]), int'(m_undr));
      chk("R9 reserved bits", int'(csr_rdata[6:4]), 0);
      chk("R7 short armed", int'(csr_rdata[7]), int'(m_short));
      chk("R7 link_short", int'(link_short), int'(m_short));
      chk("R10 irq", int'(irq), int'(irq_en && (m_sent || m_undr)));
      chk("R11 link_ready", int'(link_ready), int'(q.size() >= PKT || m_short));
      if (q.size() > 0) chk("R3 head byte", int'(link_data), int'(q[0]));
    end
  end

  task automatic drive(input bit wr, input logic [7:0] wd, input bit ps,
                       input logic [DW-1:0] pd, input bit pp, input bit dn);
    @(posedge clk); #1;
    csr_wr = wr; csr_wdata = wd; push_en = ps; push_data = pd;
    link_pop = pp; link_done = dn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 8'h00, 0, '0, 0, 0);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset csr", int'(csr_rdata), 8'h01);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset ready", int'(link_ready), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset csr", int'(csr_rdata), 8'h01);
    idle(1);
    // R2: bit 0 not writable
    drive(1, 8'h01, 0, '0, 0, 0);
    idle(1);
    // R3/R11: fill past one packet
    for (int i = 0; i < 20; i++) drive(0, 8'h00, 1, DW'(i + 8'h30), 0, 0);
    idle(1);
    // drain some, R4 done
    for (int i = 0; i < 5; i++) drive(0, 8'h00, 0, '0, 1, i == 4);
    irq_en = 1'b1;
    idle(2);
    drive(1, 8'h02, 0, '0, 0, 0);   // R4 clear
    idle(1);
    // R5: drain to empty then pop more
    for (int i = 0; i < 18; i++) drive(0, 8'h00, 0, '0, 1, 0);
    idle(2);
    // R4/R5 clear with simultaneous new events
    drive(1, 8'h0A, 0, '0, 1, 1);
    idle(1);
    drive(1, 8'h0A, 0, '0, 0, 0);
    idle(1);
    // R3: overfill
    for (int i = 0; i < 40; i++) drive(0, 8'h00, 1, DW'(i), 0, 0);
    idle(1);
    // R6: flush with push and pop in same cycle
    drive(1, 8'h04, 1, 8'hEE, 1, 0);
    idle(1);
    @(negedge clk);
    chk("R6 queue empty after flush", int'(link_ready), 0);
    chk("R6 room after flush", int'(csr_rdata[0]), 1);
    chk("R6 no underrun on flush pop", int'(csr_rdata[3]), 0);
    // R7: arm short, zero-length, then done
    drive(1, 8'h80, 0, '0, 0, 0);
    drive(1, 8'h00, 0, '0, 0, 0);   // writing 0 has no effect
    idle(1);
    @(negedge clk);
    chk("R7 short stays armed", int'(csr_rdata[7]), 1);
    drive(0, 8'h00, 0, '0, 0, 1);
    idle(1);
    // arm together with done: stays armed
    drive(1, 8'h80, 0, '0, 0, 1);
    idle(1);
    // R8: flush cancels, and flush+arm in one write
    drive(1, 8'h04, 0, '0, 0, 0);
    drive(1, 8'h80, 0, '0, 0, 0);
    drive(1, 8'h84, 0, '0, 0, 0);
    idle(1);
    @(negedge clk);
    chk("R8 flush+arm leaves short clear", int'(csr_rdata[7]), 0);
    // R10: enable toggle
    drive(0, 8'h00, 0, '0, 1, 1);
    irq_en = 1'b0;
    idle(2);
    irq_en = 1'b1;
    idle(2);
    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      drive(r < 4, (r < 4) ? 8'(($urandom() & 32'h8E) | (r == 0 ? 32'h04 : 32'h0)) : 8'h00,
            $urandom_range(0, 9) < 6, DW'($urandom()), $urandom_range(0, 9) < 5,
            $urandom_range(0, 40) == 0);
      if (i % 500 == 0) irq_en = ~irq_en;
    end
    idle(3);
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule